// File: doc/BRIEF.md
# PHY Management Register Unit

This block gives software a two-register window onto a small modelled PHY register file. Software first puts a value in the data register. It then writes the command register with a PHY address, a register index and a direction flag. The unit executes the access in the same clock cycle as the command write. A read leaves its result in the data register for the next cycle. A write moves the low 16 bits of the data register into the selected PHY register.

The unit answers only to the PHY address on its configuration input. A command addressed to any other PHY has no effect. Several registers in the modelled PHY have fixed contents: the two identifier registers and the link-partner abilities register. The link-up bit of the status register follows an external input at all times. A control write with its top bit set returns the control and advertisement registers to their reset values. The serial management bit timing and real autonegotiation are not part of this block.

Top module: `phy_mgmt_unit`

## Requirements
- R1: After reset, bus reads of the command register (offset 0x48) and the data register (offset 0x4C) return 0. A PHY read of control (index 0) returns 0x3100, and a PHY read of advertisement (index 4) returns 0.
- R2: A command write stores the written word with bit 0 (busy) cleared. Reading the command register returns that stored word. Command fields are: PHY address in bits 15:12, register index in bits 7:4, bit 1 = 1 for write and 0 for read.
- R3: A command whose PHY address field differs from cfgPhyAddr changes neither the data register nor any PHY register.
- R4: A PHY read of status (index 1) returns 0xFE28, with bit 2 set when linkUp is high at the time of the command.
- R5: PHY reads of index 2 return 0x0044, and PHY reads of index 3 return 0x1400.
- R6: A PHY read of index 5 returns 0x0DE0.
- R7: A PHY read of any index from 6 to 15 returns 0.
- R8: A PHY write to index 4 stores the low 16 bits of the data register, and a later read of index 4 returns them.
- R9: A PHY write to control with bit 15 of the data clear stores the value with bits 15 and 9 cleared.
- R10: A PHY write to control with bit 15 of the data set restores control to 0x3100 and advertisement to 0, while status still reflects linkUp.
- R11: PHY writes to indices 1, 2, 3, 5 and 6 to 15 change no register.
- R12: The data register holds the read result in the cycle after the command write. A PHY write leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPhyAddr | input | 4 | PHY address this unit answers to |
| linkUp | input | 1 | Link state shown in status bit 2 |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational, 0 when busRdEn is low or the offset is unmapped |

## Verification
Every PHY index is read at least once, and the fixed, stored and link-dependent values are told apart by their distinct constants. Reads of the status register are repeated with linkUp high and low, which separates a tracked bit from a latched one. Writes are aimed at each class of register: stored, masked, reset-triggering and ignored. Each write is followed by a read through the same port, so a dropped or misrouted write shows up. Commands carrying a foreign PHY address are sent with both read and write flags, after the data register has been loaded with a marker value, so that any effect of the command becomes visible.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int CMD_ADDR_LSB = 12;
  localparam int CMD_IDX_LSB  = 4;
  localparam int CMD_WR_BIT   = 1;
  localparam int FLD_W        = 4;

  localparam logic [FLD_W-1:0] IDX_CTRL   = 4'd0;
  localparam logic [FLD_W-1:0] IDX_STATUS = 4'd1;
  localparam logic [FLD_W-1:0] IDX_ID_HI  = 4'd2;
  localparam logic [FLD_W-1:0] IDX_ID_LO  = 4'd3;
  localparam logic [FLD_W-1:0] IDX_ADV    = 4'd4;
  localparam logic [FLD_W-1:0] IDX_PEER   = 4'd5;

  localparam logic [15:0] CTRL_DEFAULT = 16'h3100;
  localparam logic [15:0] CTRL_KEEP    = 16'h7DFF;
  localparam logic [15:0] STATUS_FIXED = 16'hFE28;
  localparam int          LINK_BIT     = 2;
  localparam logic [15:0] PEER_ABILITY = 16'h0DE0;

  typedef struct packed {
    logic             cmdWr;
    logic             dataWr;
    logic             phyRd;
    logic             ctrlLoad;
    logic             ctrlDefault;
    logic             advLoad;
    logic [FLD_W-1:0] regIdx;
  } mgmtStrobe_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int              BUS_AW   = 8,
  parameter logic [BUS_AW-1:0] CMD_OFS  = 8'h48,
  parameter logic [BUS_AW-1:0] DATA_OFS = 8'h4C
) (
  input  logic              busWrEn,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [FLD_W-1:0]  phyAddrFld,
  input  logic [FLD_W-1:0]  regIdxFld,
  input  logic              wrFlag,
  input  logic [FLD_W-1:0]  cfgPhyAddr,
  input  logic              dataTopBit,
  output mgmtStrobe_t       strobe
);
  logic cmdHit;
  logic addrMatch;
  logic phyWr;

  always_comb begin
    cmdHit    = busWrEn && (busAddr == CMD_OFS);
    addrMatch = cmdHit && (phyAddrFld == cfgPhyAddr);
    phyWr     = addrMatch && wrFlag;

    strobe.cmdWr       = cmdHit;
    strobe.dataWr      = busWrEn && (busAddr == DATA_OFS);
    strobe.phyRd       = addrMatch && !wrFlag;
    strobe.regIdx      = regIdxFld;
    strobe.ctrlDefault = phyWr && (regIdxFld == IDX_CTRL) && dataTopBit;
    strobe.ctrlLoad    = phyWr && (regIdxFld == IDX_CTRL) && !dataTopBit;
    strobe.advLoad     = phyWr && (regIdxFld == IDX_ADV);
  end
endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          REG_W  = 16,
  parameter logic [15:0] ID_HI  = 16'h0044,
  parameter logic [15:0] ID_LO  = 16'h1400
) (
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              linkUp,
  output logic [DATA_W-1:0] cmdQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              dataTopBit
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0] ctrlQ;
  logic [REG_W-1:0] advQ;
  logic [REG_W-1:0] statusVal;
  logic [REG_W-1:0] phyRdVal;

  assign dataTopBit = dataQ[REG_W-1];

  always_comb begin
    statusVal = STATUS_FIXED;
    statusVal[LINK_BIT] = linkUp;
    case (strobe.regIdx)
      IDX_CTRL:   phyRdVal = ctrlQ;
      IDX_STATUS: phyRdVal = statusVal;
      IDX_ID_HI:  phyRdVal = ID_HI;
      IDX_ID_LO:  phyRdVal = ID_LO;
      IDX_ADV:    phyRdVal = advQ;
      IDX_PEER:   phyRdVal = PEER_ABILITY;
      default:    phyRdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      dataQ <= '0;
      ctrlQ <= CTRL_DEFAULT;
      advQ  <= '0;
    end else begin
      if (strobe.cmdWr) cmdQ <= {busWrData[DATA_W-1:1], 1'b0};
      if (strobe.dataWr) dataQ <= busWrData;
      else if (strobe.phyRd) dataQ <= {{PAD_W{1'b0}}, phyRdVal};
      if (strobe.ctrlDefault) begin
        ctrlQ <= CTRL_DEFAULT;
        advQ  <= '0;
      end else begin
        if (strobe.ctrlLoad) ctrlQ <= dataQ[REG_W-1:0] & CTRL_KEEP;
        if (strobe.advLoad) advQ <= dataQ[REG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_unit.sv
module phy_mgmt_unit
  import phy_mgmt_pkg::*;
#(
  parameter int              BUS_AW   = 8,
  parameter int              DATA_W   = 32,
  parameter int              REG_W    = 16,
  parameter logic [BUS_AW-1:0] CMD_OFS  = 8'h48,
  parameter logic [BUS_AW-1:0] DATA_OFS = 8'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cfgPhyAddr,
  input  logic              linkUp,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  mgmtStrobe_t       strobe;
  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] dataQ;
  logic              dataTopBit;

  phy_mgmt_ctrl #(.BUS_AW(BUS_AW), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)) ctrlI (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .phyAddrFld(busWrData[CMD_ADDR_LSB +: FLD_W]),
    .regIdxFld (busWrData[CMD_IDX_LSB +: FLD_W]),
    .wrFlag    (busWrData[CMD_WR_BIT]),
    .cfgPhyAddr(cfgPhyAddr),
    .dataTopBit(dataTopBit),
    .strobe    (strobe)
  );

  phy_mgmt_dp #(.DATA_W(DATA_W), .REG_W(REG_W)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .linkUp    (linkUp),
    .cmdQ      (cmdQ),
    .dataQ     (dataQ),
    .dataTopBit(dataTopBit)
  );

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (busAddr == CMD_OFS) busRdData = cmdQ;
      else if (busAddr == DATA_OFS) busRdData = dataQ;
    end
  end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int              BUS_AW   = 8,
  parameter int              DATA_W   = 32,
  parameter logic [BUS_AW-1:0] CMD_OFS  = 8'h48
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        cfgPhyAddr,
  input logic              linkUp,
  input logic              busWrEn,
  input logic [BUS_AW-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] cmdQ,
  input logic [DATA_W-1:0] dataQ
);
  logic cmdIn;
  logic hitIn;
  assign cmdIn = busWrEn && (busAddr == CMD_OFS);
  assign hitIn = cmdIn && (busWrData[15:12] == cfgPhyAddr);

  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn |=> (cmdQ == {$past(busWrData[DATA_W-1:1]), 1'b0}));

  // R3
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIn && busWrData[15:12] != cfgPhyAddr) |=> $stable(dataQ));

  // R4
  status_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && !busWrData[1] && busWrData[7:4] == 4'd1)
      |=> (dataQ == {16'h0, 13'h1FC5, $past(linkUp), 2'b00}));

  // R5
  id_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && !busWrData[1] && busWrData[7:4] == 4'd2) |=> (dataQ == 32'h0044));

  // R12
  write_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && busWrData[1]) |=> $stable(dataQ));
endmodule

bind phy_mgmt_unit phy_mgmt_chk #(.BUS_AW(BUS_AW), .DATA_W(DATA_W), .CMD_OFS(CMD_OFS)) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .cfgPhyAddr(cfgPhyAddr),
  .linkUp    (linkUp),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .cmdQ      (cmdQ),
  .dataQ     (dataQ)
);

// File: tb/phy_mgmt_unit_tb.sv
module phy_mgmt_unit_tb_top;
  localparam logic [7:0] CMD  = 8'h48;
  localparam logic [7:0] DATA = 8'h4C;
  localparam logic [3:0] MYPHY = 4'h3;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  cfgPhyAddr = MYPHY;
  logic        linkUp = 1;
  logic        busWrEn = 0;
  logic        busRdEn = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  phy_mgmt_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgPhyAddr(cfgPhyAddr), .linkUp(linkUp),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  // monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    if (busRdEn && sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      total++;
      if (busRdData !== it.exp) begin
        bad++;
        $display("FAIL %s got=%h exp=%h", it.tag, busRdData, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    busWrEn = 0;
    busRdEn = 0;
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    step();
    busWrEn = 1; busAddr = a; busWrData = d;
  endtask

  task automatic rdExp(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    step();
    it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    busRdEn = 1; busAddr = a;
  endtask

  function automatic logic [31:0] cmdWord(input logic [3:0] pa, input logic [3:0] idx, input bit wr);
    return {16'h0, pa, 4'h0, idx, 2'b00, wr, 1'b0};
  endfunction

  task automatic phyWr(input logic [3:0] pa, input logic [3:0] idx, input logic [31:0] v);
    wrReg(DATA, v);
    wrReg(CMD, cmdWord(pa, idx, 1'b1));
  endtask

  task automatic phyRd(input logic [3:0] pa, input logic [3:0] idx, input logic [31:0] e, input string tag);
    wrReg(CMD, cmdWord(pa, idx, 1'b0));
    rdExp(DATA, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    rdExp(CMD, 32'h0, "R1");
    rdExp(DATA, 32'h0, "R1");
    phyRd(MYPHY, 4'd0, 32'h3100, "R1");
    phyRd(MYPHY, 4'd4, 32'h0, "R1");
    // R2 busy bit cleared on store
    wrReg(CMD, 32'h0000_3021);
    rdExp(CMD, 32'h0000_3020, "R2");
    rdExp(DATA, 32'h0044, "R12");
    // R5, R6
    phyRd(MYPHY, 4'd2, 32'h0044, "R5");
    phyRd(MYPHY, 4'd3, 32'h1400, "R5");
    phyRd(MYPHY, 4'd5, 32'h0DE0, "R6");
    // R7 unknown indices
    wrReg(DATA, 32'hFFFF_FFFF);
    phyRd(MYPHY, 4'd6, 32'h0, "R7");
    wrReg(DATA, 32'h1234_5678);
    phyRd(MYPHY, 4'd15, 32'h0, "R7");
    // R4 link tracking
    phyRd(MYPHY, 4'd1, 32'hFE2C, "R4");
    step(); linkUp = 0;
    phyRd(MYPHY, 4'd1, 32'hFE28, "R4");
    step(); linkUp = 1;
    phyRd(MYPHY, 4'd1, 32'hFE2C, "R4");
    // R8 advertisement storage
    phyWr(MYPHY, 4'd4, 32'h0000_05E1);
    rdExp(DATA, 32'h0000_05E1, "R12");
    phyRd(MYPHY, 4'd4, 32'h05E1, "R8");
    // R9 masked control write
    phyWr(MYPHY, 4'd0, 32'h0000_7FFF);
    phyRd(MYPHY, 4'd0, 32'h7DFF, "R9");
    // R3 foreign address
    wrReg(DATA, 32'h0000_AAAA);
    wrReg(CMD, cmdWord(4'h5, 4'd2, 1'b0));
    rdExp(DATA, 32'h0000_AAAA, "R3");
    phyWr(4'h5, 4'd4, 32'h0000_7777);
    phyRd(MYPHY, 4'd4, 32'h05E1, "R3");
    phyWr(4'h5, 4'd0, 32'h0000_8000);
    phyRd(MYPHY, 4'd0, 32'h7DFF, "R3");
    // R11 ignored writes
    phyWr(MYPHY, 4'd2, 32'h0000_9999);
    phyRd(MYPHY, 4'd2, 32'h0044, "R11");
    phyWr(MYPHY, 4'd5, 32'h0000_0000);
    phyRd(MYPHY, 4'd5, 32'h0DE0, "R11");
    phyWr(MYPHY, 4'd1, 32'h0000_0000);
    phyRd(MYPHY, 4'd1, 32'hFE2C, "R11");
    phyWr(MYPHY, 4'd9, 32'h0000_1111);
    phyRd(MYPHY, 4'd0, 32'h7DFF, "R11");
    phyRd(MYPHY, 4'd4, 32'h05E1, "R11");
    // R10 control reset bit
    phyWr(MYPHY, 4'd0, 32'h0000_8000);
    phyRd(MYPHY, 4'd0, 32'h3100, "R10");
    phyRd(MYPHY, 4'd4, 32'h0, "R10");
    phyRd(MYPHY, 4'd1, 32'hFE2C, "R10");
    step();
    step();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule